// File: doc/BRIEF.md
# BCD Calendar Counter with Hold Handshake

This block keeps wall-clock time and date in packed BCD: seconds, minutes, hours (24-hour), weekday, day of month, month and a two-digit year covering 2000 to 2099. It runs on the system clock and advances on a slow tick pulse (nominally 32.768 kHz) that a prescaler divides down to one step per second. Month lengths follow the calendar, and February takes 29 days whenever the year is a multiple of four.

Software reaches the block through a small register port with a write strobe, an address and a combinational read path. To set the time, software asks the counter to hold. Counting freezes at once, and a stopped status follows a fixed number of tick pulses later. Software then writes any subset of the load registers and writes zero to the hold control, which copies the load set into the running counter and restarts the one-second divider. The running time can be read at any moment through a separate, read-only live set of registers. The `time_valid` output is low whenever a hold is requested or in force.

A three-state hold controller sequences this. The states are ST_RUN (counting allowed), ST_STOPPING (hold requested, waiting for the acknowledge delay) and ST_HELD (stopped status shown). The transitions are: HOLD_REQ (ST_RUN to ST_STOPPING, when 1 is written to the hold bit), ACK_DONE (ST_STOPPING to ST_HELD, on the HOLD_TICKS-th tick pulse) and RELEASE (ST_STOPPING or ST_HELD to ST_RUN, when 0 is written to the hold bit).

Top module: `bcd_calendar`

## Requirements
- R1: After reset the time reads 00:00:00, weekday 0, day 0x01, month 0x01, year 0x00; both control registers read 0x00; `halted` is 0 and `time_valid` is 1.
- R2: While the run bit (address 0x0 bit 0) is set and no hold is active, seconds advance by one on every PRESCALE-th tick pulse. While the run bit is clear, tick pulses do not change the time.
- R3: Seconds and minutes count 0x00 to 0x59 in BCD, hours count 0x00 to 0x23, and each field wraps to 0x00 with a carry into the next field. The low digit wraps 9 to 0 and raises the high digit.
- R4: The day of month wraps to 0x01 after 0x30 (April, June, September, November), 0x31 (other months), 0x28 or 0x29 (February, 0x29 when the year value is a multiple of 4). The month wraps 0x12 to 0x01 and increments the year, the year wraps 0x99 to 0x00, and the weekday (0 to 6) steps with each day change and wraps 6 to 0.
- R5: Writing 1 to bit 0 at address 0x1 stops counting on that clock edge and drops `time_valid`. `halted` and bit 1 of address 0x1 rise on the HOLD_TICKS-th tick pulse after the write and not earlier.
- R6: When the hold starts, the load set (addresses 0x2 to 0x8: seconds, minutes, hours, weekday, day, month, year) takes the current time. Writes to the load set while running are ignored, and fields not written during the hold keep that captured value.
- R7: Writing 0 to address 0x1 during a hold copies the load set into the live time, restores `time_valid`, clears `halted`, and clears the prescaler, so that the next second comes exactly PRESCALE tick pulses later.
- R8: Address 0x0 reads back {6'b0, 24-hour bit (bit 1), run bit (bit 0)}. Address 0x1 reads {6'b0, stopped status, hold request}. The load addresses read 0x00, and addresses 0x9 to 0xF read the live seconds, minutes, hours, weekday, day, month and year.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_32k | input | 1 | One-cycle pulse per slow oscillator period |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| halted | output | 1 | Counter stopped status |
| time_valid | output | 1 | Live time is counting and trustworthy |

## Verification
A wrong carry or month-length decision shows in the live registers on the very second it occurs, as a field out of its BCD range or a day that skips or repeats. The bench therefore loads times one second before each boundary and reads every field right after the step. A stuck or late hold controller shows as `halted` rising on the wrong tick pulse, or as time moving while `time_valid` is low, within a few tick pulses of the request. A prescaler that is not cleared on release shows as the first second arriving early.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] mon;
        logic [7:0] mday;
        logic [7:0] wday;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_time_t;

    localparam int NFIELDS = 7;
    localparam int TIME_W  = NFIELDS * 8;

    localparam logic [3:0] ADDR_CTRL_A = 4'h0;
    localparam logic [3:0] ADDR_CTRL_B = 4'h1;
    localparam logic [3:0] LOAD_BASE   = 4'h2;
    localparam logic [3:0] LIVE_BASE   = 4'h9;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_STOPPING = 2'd1,
        ST_HELD     = 2'd2
    } hold_state_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] year);
        int yr;
        yr = int'(year[7:4]) * 10 + int'(year[3:0]);
        case (mon)
            8'h02:                      return ((yr % 4) == 0) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic enable,
    input  logic clear,
    output logic sec_en
);
    localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt;

    assign sec_en = tick && enable && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (tick && enable)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/cal_hold_fsm.sv
module cal_hold_fsm
    import cal_pkg::*;
#(
    parameter int HOLD_TICKS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        ctl_wr,
    input  logic        ctl_hold,
    output hold_state_t state_o,
    output logic        capture,
    output logic        reload,
    output logic        halted,
    output logic        running
);
    localparam int CW = $clog2(HOLD_TICKS + 1);
    localparam logic [CW-1:0] LASTCNT = CW'(HOLD_TICKS - 1);

    hold_state_t   state;
    logic [CW-1:0] tick_cnt;

    // State register and acknowledge-delay counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            tick_cnt <= '0;
        end else begin
            unique case (state)
                ST_RUN: begin
                    tick_cnt <= '0;
                    if (ctl_wr && ctl_hold)
                        state <= ST_STOPPING;            // HOLD_REQ
                end
                ST_STOPPING: begin
                    if (ctl_wr && !ctl_hold)
                        state <= ST_RUN;                 // RELEASE
                    else if (tick) begin
                        if (tick_cnt == LASTCNT)
                            state <= ST_HELD;            // ACK_DONE
                        tick_cnt <= tick_cnt + 1'b1;
                    end
                end
                ST_HELD: begin
                    if (ctl_wr && !ctl_hold)
                        state <= ST_RUN;                 // RELEASE
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    // Outputs
    always_comb begin
        state_o = state;
        running = (state == ST_RUN);
        halted  = (state == ST_HELD);
        capture = (state == ST_RUN) && ctl_wr && ctl_hold;
        reload  = (state != ST_RUN) && ctl_wr && !ctl_hold;
    end
endmodule

// File: rtl/cal_time_chain.sv
module cal_time_chain
    import cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sec_en,
    input  logic      load,
    input  cal_time_t load_val,
    output cal_time_t now
);
    cal_time_t nxt;

    always_comb begin
        nxt = now;
        if (now.sec == 8'h59) begin
            nxt.sec = 8'h00;
            if (now.min == 8'h59) begin
                nxt.min = 8'h00;
                if (now.hour == 8'h23) begin
                    nxt.hour = 8'h00;
                    nxt.wday = (now.wday >= 8'h06) ? 8'h00 : now.wday + 8'h01;
                    if (now.mday == last_day(now.mon, now.year)) begin
                        nxt.mday = 8'h01;
                        if (now.mon == 8'h12) begin
                            nxt.mon  = 8'h01;
                            nxt.year = (now.year == 8'h99) ? 8'h00 : bcd_inc(now.year);
                        end else begin
                            nxt.mon = bcd_inc(now.mon);
                        end
                    end else begin
                        nxt.mday = bcd_inc(now.mday);
                    end
                end else begin
                    nxt.hour = bcd_inc(now.hour);
                end
            end else begin
                nxt.min = bcd_inc(now.min);
            end
        end else begin
            nxt.sec = bcd_inc(now.sec);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            now <= '{year: 8'h00, mon: 8'h01, mday: 8'h01, wday: 8'h00,
                     hour: 8'h00, min: 8'h00, sec: 8'h00};
        else if (load)
            now <= load_val;
        else if (sec_en)
            now <= nxt;
    end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import cal_pkg::*;
#(
    parameter int PRESCALE   = 32768,
    parameter int HOLD_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_32k,
    input  logic       reg_we,
    input  logic [3:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       halted,
    output logic       time_valid
);
    logic        run_en;
    logic        mode24;
    logic        ctl_b_wr;
    logic        capture;
    logic        reload;
    logic        running;
    logic        sec_en;
    hold_state_t hstate;
    cal_time_t   now;
    cal_time_t   shadow;
    logic [TIME_W-1:0] now_v;
    logic [TIME_W-1:0] shadow_v;

    assign ctl_b_wr   = reg_we && (reg_addr == ADDR_CTRL_B);
    assign now_v      = now;
    assign shadow     = shadow_v;
    assign time_valid = running;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_en <= 1'b0;
            mode24 <= 1'b0;
        end else if (reg_we && reg_addr == ADDR_CTRL_A) begin
            run_en <= reg_wdata[0];
            mode24 <= reg_wdata[1];
        end
    end

    // Load set: captured at hold entry, writable only during a hold
    for (genvar g = 0; g < NFIELDS; g++) begin : g_shadow
        localparam logic [3:0] FADDR = LOAD_BASE + 4'(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                shadow_v[g*8 +: 8] <= '0;
            else if (capture)
                shadow_v[g*8 +: 8] <= now_v[g*8 +: 8];
            else if (!running && reg_we && reg_addr == FADDR)
                shadow_v[g*8 +: 8] <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr == ADDR_CTRL_A)
            reg_rdata = {6'b0, mode24, run_en};
        else if (reg_addr == ADDR_CTRL_B)
            reg_rdata = {6'b0, halted, (hstate != ST_RUN)};
        else if (reg_addr >= LIVE_BASE)
            reg_rdata = now_v[(int'(reg_addr) - int'(LIVE_BASE)) * 8 +: 8];
    end

    cal_hold_fsm #(.HOLD_TICKS(HOLD_TICKS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_32k),
        .ctl_wr   (ctl_b_wr),
        .ctl_hold (reg_wdata[0]),
        .state_o  (hstate),
        .capture  (capture),
        .reload   (reload),
        .halted   (halted),
        .running  (running)
    );

    cal_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_32k),
        .enable (running && run_en),
        .clear  (reload),
        .sec_en (sec_en)
    );

    cal_time_chain u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_en   (sec_en),
        .load     (reload),
        .load_val (shadow),
        .now      (now)
    );
endmodule

// File: rtl/bcd_calendar_sva.sv
module bcd_calendar_sva
    import cal_pkg::*;
#(
    parameter int HOLD_TICKS = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_32k,
    input logic       reg_we,
    input logic [3:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       halted,
    input logic       time_valid,
    input cal_time_t  now
);
    logic       waiting;
    logic [7:0] wait_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            waiting  <= 1'b0;
            wait_cnt <= '0;
        end else if (reg_we && reg_addr == ADDR_CTRL_B && !reg_wdata[0]) begin
            waiting  <= 1'b0;
            wait_cnt <= '0;
        end else if (reg_we && reg_addr == ADDR_CTRL_B && reg_wdata[0] && time_valid) begin
            waiting  <= 1'b1;
            wait_cnt <= '0;
        end else if (waiting && halted) begin
            waiting <= 1'b0;
        end else if (waiting && tick_32k && wait_cnt != 8'hFF) begin
            wait_cnt <= wait_cnt + 8'd1;
        end
    end

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (time_valid && $past(time_valid) && now.sec != $past(now.sec)) |->
        ((now.sec == bcd_inc($past(now.sec))) || (now.sec == 8'h00 && $past(now.sec) == 8'h59))); // R3

    AST_FIELDS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (now.sec[3:0] <= 4'd9 && now.sec <= 8'h59 && now.min[3:0] <= 4'd9 && now.min <= 8'h59
         && now.hour[3:0] <= 4'd9 && now.hour <= 8'h23 && now.wday <= 8'h06)); // R3

    AST_DAY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (now.mday >= 8'h01 && now.mday <= last_day(now.mon, now.year)
         && now.mon >= 8'h01 && now.mon <= 8'h12)); // R4

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!time_valid && $past(!time_valid)) |-> $stable(now)); // R5

    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        waiting |-> (wait_cnt <= 8'(HOLD_TICKS))); // R5

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_CTRL_B && reg_wdata == 8'h00 && !time_valid)
        |=> (time_valid && !halted)); // R7
endmodule

bind bcd_calendar bcd_calendar_sva #(.HOLD_TICKS(HOLD_TICKS)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_32k   (tick_32k),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .halted     (halted),
    .time_valid (time_valid),
    .now        (now)
);

// File: tb/bcd_calendar_test.sv
module bcd_calendar_test;
    localparam int PRE  = 4;
    localparam int HOLD = 2;

    localparam logic [3:0] A_CTLA = 4'h0, A_CTLB = 4'h1, A_LSEC = 4'h2;
    localparam logic [3:0] A_SEC = 4'h9, A_MIN = 4'hA, A_HOUR = 4'hB, A_WDAY = 4'hC;
    localparam logic [3:0] A_MDAY = 4'hD, A_MON = 4'hE, A_YEAR = 4'hF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       halted;
    logic       time_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t exp_q[$];
    event  sample_ev;

    always #10 clk = ~clk;

    bcd_calendar #(.PRESCALE(PRE), .HOLD_TICKS(HOLD)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_32k   (tick_32k),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .halted     (halted),
        .time_valid (time_valid)
    );

    // Monitor: pops expected items and compares away from the clock edge
    always begin
        @(sample_ev);
        #2;
        while (exp_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = exp_q.pop_front();
            case (it.kind)
                0:       act = reg_rdata;
                1:       act = {7'b0, halted};
                default: act = {7'b0, time_valid};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(input int kind, input logic [3:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(negedge clk);
        if (kind == 0) reg_addr = a;
        it.kind = kind; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        -> sample_ev;
    endtask

    task automatic peek(input logic [3:0] a, input logic [7:0] e, input string tag);
        push(0, a, e, tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_32k = 1'b1;
            @(negedge clk); tick_32k = 1'b0;
        end
    endtask

    task automatic hold_on();
        wr(A_CTLB, 8'h01);
        ticks(HOLD);
    endtask

    task automatic load_all(input logic [7:0] s, mi, h, wd, d, mo, y);
        wr(A_LSEC + 4'd0, s);  wr(A_LSEC + 4'd1, mi); wr(A_LSEC + 4'd2, h);
        wr(A_LSEC + 4'd3, wd); wr(A_LSEC + 4'd4, d);  wr(A_LSEC + 4'd5, mo);
        wr(A_LSEC + 4'd6, y);
    endtask

    task automatic set_time(input logic [7:0] s, mi, h, wd, d, mo, y);
        hold_on();
        load_all(s, mi, h, wd, d, mo, y);
        wr(A_CTLB, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(A_SEC, 8'h00, "R1 sec"); peek(A_MIN, 8'h00, "R1 min");
        peek(A_HOUR, 8'h00, "R1 hour"); peek(A_WDAY, 8'h00, "R1 wday");
        peek(A_MDAY, 8'h01, "R1 mday"); peek(A_MON, 8'h01, "R1 mon");
        peek(A_YEAR, 8'h00, "R1 year"); peek(A_CTLA, 8'h00, "R1 ctla");
        peek(A_CTLB, 8'h00, "R1 ctlb");
        push(1, 4'h0, 8'h00, "R1 halted"); push(2, 4'h0, 8'h01, "R1 valid");

        // R2 no counting while run bit clear
        ticks(8);
        peek(A_SEC, 8'h00, "R2 stopped when disabled");

        // R8 control readback, R2 rate
        wr(A_CTLA, 8'h03);
        peek(A_CTLA, 8'h03, "R8 ctla readback");
        ticks(PRE - 1);
        peek(A_SEC, 8'h00, "R2 before boundary");
        ticks(1);
        peek(A_SEC, 8'h01, "R2 one second");

        // R6 load writes while running are ignored
        wr(A_LSEC, 8'h45);
        ticks(2);                      // prescaler part-way

        // R5 hold handshake
        wr(A_CTLB, 8'h01);
        push(2, 4'h0, 8'h00, "R5 valid drops");
        peek(A_CTLB, 8'h01, "R5 request bit");
        ticks(HOLD - 1);
        push(1, 4'h0, 8'h00, "R5 not yet halted");
        ticks(1);
        push(1, 4'h0, 8'h01, "R5 halted");
        peek(A_CTLB, 8'h03, "R5 status bit");
        ticks(8);
        peek(A_SEC, 8'h01, "R5 frozen");
        peek(A_LSEC, 8'h00, "R8 load reg reads zero");

        // R7 release, R6 captured values used
        wr(A_CTLB, 8'h00);
        peek(A_SEC, 8'h01, "R6 running write ignored");
        push(2, 4'h0, 8'h01, "R7 valid back");
        push(1, 4'h0, 8'h00, "R7 halted clear");
        ticks(PRE - 1);
        peek(A_SEC, 8'h01, "R7 prescaler cleared");
        ticks(1);
        peek(A_SEC, 8'h02, "R7 first second");

        // R3 R4 non-leap February end
        set_time(8'h58, 8'h59, 8'h23, 8'h06, 8'h28, 8'h02, 8'h23);
        ticks(PRE);
        peek(A_SEC, 8'h59, "R3 sec 59");
        ticks(PRE);
        peek(A_SEC, 8'h00, "R3 sec wrap"); peek(A_MIN, 8'h00, "R3 min wrap");
        peek(A_HOUR, 8'h00, "R3 hour wrap"); peek(A_MDAY, 8'h01, "R4 feb 28 end");
        peek(A_MON, 8'h03, "R4 march"); peek(A_WDAY, 8'h00, "R4 wday wrap");
        peek(A_YEAR, 8'h23, "R4 year kept");

        // R4 leap February
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
        ticks(PRE);
        peek(A_MDAY, 8'h29, "R4 leap day"); peek(A_MON, 8'h02, "R4 leap month");
        peek(A_WDAY, 8'h03, "R4 wday step");

        // R6 partial load keeps captured date
        hold_on();
        wr(A_LSEC + 4'd0, 8'h59); wr(A_LSEC + 4'd1, 8'h59); wr(A_LSEC + 4'd2, 8'h23);
        wr(A_CTLB, 8'h00);
        peek(A_MDAY, 8'h29, "R6 unwritten day kept");
        ticks(PRE);
        peek(A_MDAY, 8'h01, "R4 leap feb end"); peek(A_MON, 8'h03, "R4 leap march");
        peek(A_WDAY, 8'h04, "R6 unwritten wday kept");

        // R4 year wrap
        set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
        ticks(PRE);
        peek(A_YEAR, 8'h00, "R4 year wrap"); peek(A_MON, 8'h01, "R4 month wrap");
        peek(A_MDAY, 8'h01, "R4 dec end");

        // R4 thirty-day month
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h05);
        ticks(PRE);
        peek(A_MDAY, 8'h01, "R4 april end"); peek(A_MON, 8'h05, "R4 may");
        peek(A_WDAY, 8'h02, "R4 wday");

        // R3 BCD digit carry in minutes
        set_time(8'h59, 8'h09, 8'h12, 8'h00, 8'h15, 8'h06, 8'h10);
        ticks(PRE);
        peek(A_SEC, 8'h00, "R3 sec"); peek(A_MIN, 8'h10, "R3 digit carry");
        peek(A_HOUR, 8'h12, "R3 hour kept"); peek(A_MDAY, 8'h15, "R3 day kept");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule